// File: doc/BRIEF.md
# Iterative Decode Termination Controller

This block decides how many half-iterations an iterative soft-decision decoder spends on one data block. A half-iteration is one full pass of the block through the decoder. Two half-iterations, natural order then interleaved order, make one full iteration. A start pulse launches the block. The controller then requests passes one at a time. While each pass runs it watches the stream of soft outputs and tracks whether every magnitude in that pass is strictly greater than a programmed threshold.

After each pass it decides between two actions. It either starts another pass or requests the output write phase, using programmed lower and upper bounds on the half-iteration count. When the write phase completes, it publishes the block statistics and drops busy. The statistics are the number of half-iterations run and a one-cycle flag that is set when the threshold test caused the stop.

The decoding arithmetic, the memories and the address generation sit outside the block. Toward them, the block's view is a valid-qualified stream of soft values with a pass-done strobe and a write-done strobe.

The control sequence has six states:
- IDLE: waits for an accepted start.
- ISSUE: pulses the pass request.
- RUN: consumes soft values until pass done.
- DECIDE: evaluates the bounds and the threshold result.
- WREQ: pulses the write request.
- WRITE: waits for write done.

The transitions are:
- IDLE→ISSUE on start.
- ISSUE→RUN always.
- RUN→DECIDE on pass done.
- DECIDE→ISSUE to continue.
- DECIDE→WREQ to stop.
- WREQ→WRITE always.
- WRITE→IDLE on write done.

Top module: `iter_term_ctrl`

## Requirements
- R1: `busy_o` is high in the cycle after a `start_i` pulse seen in IDLE, and `pass_start_o` pulses in that same cycle. A `start_i` seen while busy is dropped: it starts no further block after the current one ends.
- R2: At least `min_half_i` half-iterations run, whatever the threshold result. A minimum greater than the effective maximum is reduced to that maximum.
- R3: Decoding always stops once the effective maximum count of half-iterations has completed. The effective maximum is `max_half_i`, or 1 when `max_half_i` is 0.
- R4: After a pass with count ≥ effective minimum, decoding stops early only if every valid soft value in that pass had magnitude strictly greater than `thresh_i`. A magnitude equal to the threshold blocks the early stop.
- R5: `pass_order_o` is 0 (natural) during the 1st, 3rd, 5th… pass and 1 (interleaved) during the 2nd, 4th… pass. It is valid while `pass_start_o` is high.
- R6: `half_cnt_o` keeps the previous block's count until the cycle after `wr_done_i`, then shows this block's count. `et_o` is high for exactly that one cycle, and only if the stop came from the threshold test with the count below the effective maximum.
- R7: While `wr_start_o` is high, `wr_order_o` is 0 (natural) if the count of half-iterations run is odd and 1 (interleaved) if it is even.
- R8: `busy_o` falls in the cycle after `wr_done_i` is seen in WRITE.
- R9: `hard_o` equals the sign bit (bit SW-1) of the two's-complement `soft_i`.
- R10: The most negative soft code (4'b1000 for SW=4) has magnitude 2^(SW-1), so it exceeds every threshold.
- R11: Bounds and threshold are captured at the accepted start. Changes to them while busy do not affect the current block.
- R12: After reset, `busy_o`, `pass_start_o`, `wr_start_o` and `et_o` are 0, and `half_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-block pulse |
| min_half_i | input | HW (5) | Minimum half-iterations |
| max_half_i | input | HW (5) | Maximum half-iterations |
| thresh_i | input | SW-1 (3) | Magnitude threshold for early stop |
| pass_start_o | output | 1 | Request one decoder pass |
| pass_order_o | output | 1 | Order of the requested pass, 0 natural, 1 interleaved |
| soft_vld_i | input | 1 | Soft value valid |
| soft_i | input | SW (4) | Two's-complement soft output |
| pass_done_i | input | 1 | Decoder finished the current pass |
| hard_o | output | 1 | Hard decision of `soft_i` |
| wr_start_o | output | 1 | Request the output write phase |
| wr_order_o | output | 1 | Output address order, 0 natural, 1 interleaved |
| wr_done_i | input | 1 | Last output bit written |
| busy_o | output | 1 | Block in progress |
| half_cnt_o | output | HW (5) | Half-iterations run on the last block |
| et_o | output | 1 | One-cycle early-termination flag |

## Verification
The errors are visible at the ports within one pass:
- A corrupted half-iteration counter shows at the next decision as an extra or missing `pass_start_o` pulse. It also flips `pass_order_o` or `wr_order_o` at the following request.
- A threshold flag that fails to clear, or clears wrongly, changes the number of passes at the first pass that reaches the minimum. It also changes `et_o`.
- A wrong state register shows in the same cycle through `busy_o` or the request pulses.

The sweep covers every minimum and maximum from 0 to 6 against several per-pass threshold patterns, so each of these effects lands on a counted check within a few cycles of its cause.

// File: rtl/iter_term_pkg.sv
package iter_term_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RUN,
        ST_DECIDE,
        ST_WREQ,
        ST_WRITE
    } ctl_state_e;
endpackage

// File: rtl/iter_term_monitor.sv
// Sticky "every magnitude above threshold" flag for one pass.
module iter_term_monitor #(
    parameter int SW = 4,
    localparam int TW = SW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          vld_i,
    input  logic [SW-1:0] soft_i,
    input  logic [TW-1:0] thresh_i,
    output logic          all_ok_o
);
    logic [SW-1:0] mag;
    logic          above;
    logic          ok_q;

    // Magnitude in SW unsigned bits: the most negative code maps to 2^(SW-1).
    always_comb begin
        mag   = soft_i[SW-1] ? (~soft_i + 1'b1) : soft_i;
        above = mag > {1'b0, thresh_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ok_q <= 1'b0;
        else if (clear_i)
            ok_q <= 1'b1;
        else if (vld_i && !above)
            ok_q <= 1'b0;
    end

    assign all_ok_o = ok_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_q && !clear_i) |=> !ok_q); // R4

    AST_FLAG_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clear_i && soft_i == {1'b1, {(SW-1){1'b0}}}) |=> (ok_q == $past(ok_q))); // R10
endmodule

// File: rtl/iter_term_bounds.sv
// Half-iteration counter with clamped minimum/maximum and stop decision.
module iter_term_bounds #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [HW-1:0] min_i,
    input  logic [HW-1:0] max_i,
    input  logic          inc_i,
    input  logic          all_ok_i,
    output logic [HW-1:0] cnt_o,
    output logic [HW-1:0] emin_o,
    output logic [HW-1:0] emax_o,
    output logic          stop_o,
    output logic          early_o
);
    localparam logic [HW-1:0] ONE = HW'(1);

    logic [HW-1:0] cnt_q, emin_q, emax_q;
    logic [HW-1:0] max_eff, min_eff;
    logic          at_max, min_met;

    always_comb begin
        max_eff = (max_i == '0) ? ONE : max_i;
        min_eff = (min_i > max_eff) ? max_eff : min_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            emin_q <= '0;
            emax_q <= ONE;
        end else if (load_i) begin
            cnt_q  <= '0;
            emin_q <= min_eff;
            emax_q <= max_eff;
        end else if (inc_i) begin
            cnt_q  <= cnt_q + ONE;
        end
    end

    always_comb begin
        at_max  = cnt_q >= emax_q;
        min_met = cnt_q >= emin_q;
        stop_o  = at_max || (min_met && all_ok_i);
        early_o = !at_max && min_met && all_ok_i;
    end

    assign cnt_o  = cnt_q;
    assign emin_o = emin_q;
    assign emax_o = emax_q;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= emax_q); // R3

    AST_MAX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        emax_q != '0); // R3
endmodule

// File: rtl/iter_term_stats.sv
// Per-block statistics published after the write phase.
module iter_term_stats #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [HW-1:0] cnt_i,
    input  logic          early_i,
    output logic [HW-1:0] half_cnt_o,
    output logic          et_o
);
    logic [HW-1:0] cnt_q;
    logic          et_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            et_q  <= 1'b0;
        end else begin
            et_q <= cap_i && early_i;
            if (cap_i)
                cnt_q <= cnt_i;
        end
    end

    assign half_cnt_o = cnt_q;
    assign et_o       = et_q;

    AST_ET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        et_q |=> !et_q); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/iter_term_ctrl.sv
module iter_term_ctrl #(
    parameter int SW = 4,
    parameter int HW = 5,
    localparam int TW = SW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [HW-1:0] min_half_i,
    input  logic [HW-1:0] max_half_i,
    input  logic [TW-1:0] thresh_i,
    output logic          pass_start_o,
    output logic          pass_order_o,
    input  logic          soft_vld_i,
    input  logic [SW-1:0] soft_i,
    input  logic          pass_done_i,
    output logic          hard_o,
    output logic          wr_start_o,
    output logic          wr_order_o,
    input  logic          wr_done_i,
    output logic          busy_o,
    output logic [HW-1:0] half_cnt_o,
    output logic          et_o
);
    import iter_term_pkg::*;

    ctl_state_e    state_q, state_d;
    logic [TW-1:0] thresh_q;
    logic          load, inc, cap, clear, mon_vld;
    logic          all_ok, stop, early;
    logic [HW-1:0] cnt, emin, emax;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Threshold captured with the bounds at an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            thresh_q <= '0;
        else if (load)
            thresh_q <= thresh_i;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_RUN;
            ST_RUN:    if (pass_done_i) state_d = ST_DECIDE;
            ST_DECIDE: state_d = stop ? ST_WREQ : ST_ISSUE;
            ST_WREQ:   state_d = ST_WRITE;
            ST_WRITE:  if (wr_done_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and internal strobes
    always_comb begin
        busy_o       = 1'b1;
        pass_start_o = 1'b0;
        wr_start_o   = 1'b0;
        load         = 1'b0;
        inc          = 1'b0;
        cap          = 1'b0;
        clear        = 1'b0;
        mon_vld      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load   = start_i;
            end
            ST_ISSUE: begin
                pass_start_o = 1'b1;
                clear        = 1'b1;
            end
            ST_RUN: begin
                mon_vld = soft_vld_i;
                inc     = pass_done_i;
            end
            ST_DECIDE: ;
            ST_WREQ:   wr_start_o = 1'b1;
            ST_WRITE:  cap = wr_done_i;
            default:   busy_o = 1'b0;
        endcase
        pass_order_o = cnt[0];
        wr_order_o   = ~cnt[0];
        hard_o       = soft_i[SW-1];
    end

    iter_term_monitor #(.SW(SW)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .vld_i    (mon_vld),
        .soft_i   (soft_i),
        .thresh_i (thresh_q),
        .all_ok_o (all_ok)
    );

    iter_term_bounds #(.HW(HW)) u_bnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .min_i    (min_half_i),
        .max_i    (max_half_i),
        .inc_i    (inc),
        .all_ok_i (all_ok),
        .cnt_o    (cnt),
        .emin_o   (emin),
        .emax_o   (emax),
        .stop_o   (stop),
        .early_o  (early)
    );

    iter_term_stats #(.HW(HW)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .cnt_i      (cnt),
        .early_i    (early),
        .half_cnt_o (half_cnt_o),
        .et_o       (et_o)
    );

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R1

    AST_MIN_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> (cnt >= emin)); // R2

    AST_ET_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        et_o |-> (half_cnt_o < emax)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pass_start_o && !wr_start_o)); // R8

    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wr_done_i)); // R8
endmodule

// File: tb/sim_iter_term_ctrl.sv
module sim_iter_term_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVAL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] min_half_i = '0;
    logic [4:0] max_half_i = '0;
    logic [2:0] thresh_i = '0;
    logic       soft_vld_i = 1'b0;
    logic [3:0] soft_i = '0;
    logic       pass_done_i = 1'b0;
    logic       wr_done_i = 1'b0;
    logic       pass_start_o, pass_order_o, hard_o, wr_start_o, wr_order_o, busy_o, et_o;
    logic [4:0] half_cnt_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [4:0] prev_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iter_term_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .min_half_i(min_half_i), .max_half_i(max_half_i), .thresh_i(thresh_i),
        .pass_start_o(pass_start_o), .pass_order_o(pass_order_o),
        .soft_vld_i(soft_vld_i), .soft_i(soft_i), .pass_done_i(pass_done_i),
        .hard_o(hard_o), .wr_start_o(wr_start_o), .wr_order_o(wr_order_o),
        .wr_done_i(wr_done_i), .busy_o(busy_o), .half_cnt_o(half_cnt_o), .et_o(et_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected <=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] neg4(input int x);
        return 4'(16 - x);
    endfunction

    // Soft value j of a pass; ok=1 gives all magnitudes above thr (R4, R10)
    function automatic logic [3:0] pick(input bit ok, input int thr, input int j);
        if (!ok && j == 2)
            return neg4(thr);            // magnitude equal to threshold
        if (thr >= 7 || j == 3)
            return 4'b1000;              // most negative code, magnitude 8
        return (j % 2) ? neg4(thr + 1) : 4'(thr + 1);
    endfunction

    task automatic run_block(input int mi, input int ma, input int thr, input logic [31:0] okm);
        int emax, emin, k, exp_k;
        bit exp_et, done;
        emax = (ma == 0) ? 1 : ma;
        emin = (mi > emax) ? emax : mi;
        exp_k = 0;
        exp_et = 0;
        for (int p = 1; p <= emax; p++) begin
            exp_k = p;
            if (p >= emin && okm[p-1] && p < emax) begin exp_et = 1; break; end
            if (p >= emin && okm[p-1]) break;
        end

        min_half_i = 5'(mi);
        max_half_i = 5'(ma);
        thresh_i   = 3'(thr);
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 busy after start", int'(busy_o), 1);
        k = 0;
        done = 0;
        while (!done) begin
            if (!pass_start_o) begin
                chk("R3 pass or write request expected", int'(pass_start_o), 1);
                done = 1;
            end else begin
                k = k + 1;
                chk("R5 pass order", int'(pass_order_o), (k - 1) % 2);
                @(negedge clk);
                for (int j = 0; j < NVAL; j++) begin
                    soft_vld_i = 1'b1;
                    soft_i = pick(okm[k-1], thr, j);
                    if (k == 1 && j == 0) begin
                        // R11 / R1: disturb config and pulse start while busy
                        start_i    = 1'b1;
                        min_half_i = 5'd0;
                        max_half_i = 5'd31;
                        thresh_i   = 3'(7 - thr);
                    end
                    #1;
                    chk("R9 hard decision", int'(hard_o), int'(soft_i[3]));
                    @(negedge clk);
                    start_i = 1'b0;
                end
                soft_vld_i = 1'b0;
                pass_done_i = 1'b1;
                @(negedge clk);
                pass_done_i = 1'b0;
                @(negedge clk);
                if (wr_start_o) done = 1;
                if (k > 40) done = 1;
            end
        end
        chk("R2 R3 R4 R11 half-iteration count", k, exp_k);
        chk("R7 write order", int'(wr_order_o), (k % 2 == 0) ? 1 : 0);
        chk("R6 count held before write done", int'(half_cnt_o), int'(prev_cnt));
        @(negedge clk);
        @(negedge clk);
        wr_done_i = 1'b1;
        @(negedge clk);
        wr_done_i = 1'b0;
        chk("R8 busy falls after write done", int'(busy_o), 0);
        chk("R6 half count", int'(half_cnt_o), exp_k);
        chk("R6 early flag", int'(et_o), int'(exp_et));
        prev_cnt = 5'(exp_k);
        @(negedge clk);
        chk("R6 early flag one cycle", int'(et_o), 0);
        chk("R1 dropped start did not restart", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", int'(busy_o), 0);
        chk("R12 reset pass request", int'(pass_start_o), 0);
        chk("R12 reset write request", int'(wr_start_o), 0);
        chk("R12 reset early flag", int'(et_o), 0);
        chk("R12 reset count", int'(half_cnt_o), 0);

        for (int mi = 0; mi <= 6; mi++) begin
            for (int ma = 0; ma <= 6; ma++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [31:0] okm;
                    case (m)
                        0: okm = 32'h0;
                        1: okm = 32'hFFFF_FFFF;
                        2: okm = 32'h4;
                        default: okm = 32'hA;
                    endcase
                    run_block(mi, ma, (mi + ma + m) % 8, okm);
                end
            end
        end
        // R10: threshold 7 can only be beaten by the most negative code
        run_block(0, 5, 7, 32'h1);
        // R4: equal magnitudes on every pass run to the maximum
        run_block(0, 9, 3, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule